// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a word-wide parallel NOR-style flash. The host uses ordinary bus write cycles: both chip-enable and write-enable are held low for each one. The block decodes the software-unlock command sequences carried by those writes and starts one of three timed internal operations: program a single word, erase one uniform sector, or erase one block of the non-uniform block map. While an operation runs, the block holds a busy flag high and drives an active-low ready/busy line low.

The storage behind the sequencer is a register-file stand-in. Each cell represents `2**GRAIN_W` words of the address space, so the default has 1024 cells of 1 KWord. Program and erase times are cycle counts set by parameters. An erase clears one cell per cycle and never ends before its span has been walked. A write-protect input, when low, shields two boot regions: the lowest 8 KWord and the highest 8 KWord. Any command whose target touches either region is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus write happens only while `ce_ni` and `we_ni` are both low. Its address is the value present when the second of the two goes low. Its data is the value present when the first of the two goes high. The write takes effect at that release.
- R2: Every command begins with data low byte AAh to address 555h, then 55h to address 2AAh. Only address bits [10:0] and data bits [7:0] are compared. A third write of A0h to 555h selects program. A third write of 80h to 555h, followed by the same two unlock writes again, selects erase.
- R3: In program, the fourth write launches the operation. The cell at `addr[ADDR_W-1:GRAIN_W]` becomes its old value AND the written data, so bits can only be cleared.
- R4: In erase, a final write whose data low byte is 50h sets every cell of the aligned 2 KWord sector containing the written address to FFFFh.
- R5: In erase, a final write whose data low byte is 30h sets to FFFFh the block containing the written address. From address 0 upward the blocks are 8 KWord, 4 KWord, 4 KWord and 16 KWord, and every block after those is an aligned 32 KWord block.
- R6: A write that does not match the expected step drops the partial sequence and returns to the idle state. A later command needs the full prefix again.
- R7: Every write that completes while an operation is running is ignored. It neither changes the stored data nor advances a sequence.
- R8: While `wp_ni` is low, a program or erase is dropped without starting if its target range includes any word below 8 KWord or any word in the top 8 KWord of the address space. While `wp_ni` is high, the same commands run.
- R9: `busy_o` rises on the clock edge that sees the launching write released. It stays high for `PROG_CYC` cycles for a program, and for max(`ERASE_CYC`, cells in range + 1) cycles for an erase. `ry_by_o` is its inverse.
- R10: After reset, every cell reads FFFFh, `busy_o` is low and `ry_by_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| wp_ni | input | 1 | Boot-region write protect, active low |
| addr_i | input | ADDR_W | Word address for bus writes and reads |
| data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Content of the cell addressed by `addr_i` |
| busy_o | output | 1 | High while an internal operation runs |
| ry_by_o | output | 1 | Ready (high) / busy (low) |

## Verification
Program is swept over every cell with a per-cell pattern, then applied a second time to a subset. The second pass separates an AND merge from an overwrite. Sector erase is swept over every third sector, and block erase is run on each block of the map in turn. The busy length is measured each time, which separates the short boot blocks from the 32 KWord blocks where the walk outlasts the timer. Separate passes cover the following stimuli:
- broken unlock prefixes;
- an unknown erase opcode;
- a full command sequence issued while busy;
- write-enable pulses with chip-enable high;
- an address and data that change while the strobe is active;
- protected and unprotected targets at both ends of the address space.

Each of these must leave exactly the predicted cells modified.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PSET, S_ESET, S_EUNL1, S_EUNL2
  } seq_state_e;

  localparam logic [10:0] ADR_KEY1   = 11'h555;
  localparam logic [10:0] ADR_KEY2   = 11'h2AA;
  localparam logic [7:0]  DAT_KEY1   = 8'hAA;
  localparam logic [7:0]  DAT_KEY2   = 8'h55;
  localparam logic [7:0]  OPC_PROG   = 8'hA0;
  localparam logic [7:0]  OPC_ERASE  = 8'h80;
  localparam logic [7:0]  OPC_SECT   = 8'h50;
  localparam logic [7:0]  OPC_BLK    = 8'h30;

  localparam logic [31:0] SECT_WORDS = 32'd2048;
  localparam logic [31:0] BOOT_WORDS = 32'd8192;
  localparam logic [31:0] BIG_BLK    = 32'd32768;

  // non-uniform block map, low addresses first
  function automatic logic [31:0] blk_base(input logic [31:0] a);
    if (a < 32'd8192)       return 32'd0;
    else if (a < 32'd12288) return 32'd8192;
    else if (a < 32'd16384) return 32'd12288;
    else if (a < 32'd32768) return 32'd16384;
    else                    return a & ~(BIG_BLK - 32'd1);
  endfunction

  function automatic logic [31:0] blk_size(input logic [31:0] a);
    if (a < 32'd8192)       return 32'd8192;
    else if (a < 32'd16384) return 32'd4096;
    else if (a < 32'd32768) return 32'd16384;
    else                    return BIG_BLK;
  endfunction

endpackage

// File: rtl/fcs_bus_capture.sv
module fcs_bus_capture #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic              wr_v_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o
);
  logic strobe, strobe_q;
  assign strobe = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q) wr_addr_o <= addr_i;  // later falling edge
      if (strobe)              wr_data_o <= data_i;  // last value before release
    end
  end

  assign wr_v_o = strobe_q & ~strobe;
endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int GRAIN_W = 10,
  localparam int CELL_W = ADDR_W - GRAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_v_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  output logic              start_o,
  output logic              prog_o,
  output logic [CELL_W-1:0] lo_cell_o,
  output logic [CELL_W-1:0] hi_cell_o,
  output logic              idle_o
);
  localparam logic [31:0] TOP_BOOT = 32'((64'd1 << ADDR_W) - 64'(BOOT_WORDS));

  seq_state_e state_q, state_d;
  logic [31:0] a32, rng_lo, rng_hi;
  logic [7:0]  d8;
  logic        key1, key2, prot;

  assign a32  = 32'(wr_addr_i);
  assign d8   = wr_data_i[7:0];
  assign key1 = (wr_addr_i[10:0] == ADR_KEY1) && (d8 == DAT_KEY1);
  assign key2 = (wr_addr_i[10:0] == ADR_KEY2) && (d8 == DAT_KEY2);

  always_comb begin
    if (state_q == S_PSET) begin
      rng_lo = a32;
      rng_hi = a32;
    end else if (d8 == OPC_SECT) begin
      rng_lo = a32 & ~(SECT_WORDS - 32'd1);
      rng_hi = rng_lo + SECT_WORDS - 32'd1;
    end else begin
      rng_lo = blk_base(a32);
      rng_hi = rng_lo + blk_size(a32) - 32'd1;
    end
  end

  assign prot = !wp_ni && ((rng_lo < BOOT_WORDS) || (rng_hi >= TOP_BOOT));

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    if (wr_v_i) begin
      state_d = S_IDLE;
      if (!busy_i) begin
        unique case (state_q)
          S_IDLE:  if (key1) state_d = S_UNL1;
          S_UNL1:  if (key2) state_d = S_UNL2;
          S_UNL2:  if (wr_addr_i[10:0] == ADR_KEY1) begin
                     if (d8 == OPC_PROG)       state_d = S_PSET;
                     else if (d8 == OPC_ERASE) state_d = S_ESET;
                   end
          S_PSET:  start_o = !prot;
          S_ESET:  if (key1) state_d = S_EUNL1;
          S_EUNL1: if (key2) state_d = S_EUNL2;
          S_EUNL2: start_o = !prot && (d8 == OPC_SECT || d8 == OPC_BLK);
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign prog_o    = (state_q == S_PSET);
  assign lo_cell_o = rng_lo[ADDR_W-1:GRAIN_W];
  assign hi_cell_o = rng_hi[ADDR_W-1:GRAIN_W];
  assign idle_o    = (state_q == S_IDLE);
endmodule

// File: rtl/fcs_op_engine.sv
module fcs_op_engine #(
  parameter int CELL_W    = 10,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              prog_i,
  input  logic [CELL_W-1:0] lo_cell_i,
  input  logic [CELL_W-1:0] hi_cell_i,
  input  logic [15:0]       pdata_i,
  input  logic [15:0]       arr_old_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic              arr_prog_o,
  output logic [CELL_W-1:0] arr_idx_o,
  output logic [15:0]       arr_wdata_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CELL_W:0]   ptr_q;
  logic [CELL_W-1:0] hi_q;
  logic [15:0]       pdata_q;
  logic              prog_q, walking, done;

  assign walking = busy_o & ~prog_q & (ptr_q <= {1'b0, hi_q});
  assign done    = busy_o & (cnt_q == '0) & (prog_q | ~walking);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      hi_q    <= '0;
      pdata_q <= '0;
      prog_q  <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o  <= 1'b1;
        cnt_q   <= prog_i ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
        ptr_q   <= {1'b0, lo_cell_i};
        hi_q    <= hi_cell_i;
        pdata_q <= pdata_i;
        prog_q  <= prog_i;
      end
    end else begin
      if (walking)        ptr_q  <= ptr_q + 1'b1;
      if (cnt_q != '0)    cnt_q  <= cnt_q - 1'b1;
      if (done)           busy_o <= 1'b0;
    end
  end

  assign arr_we_o    = walking | (done & prog_q);
  assign arr_prog_o  = prog_q;
  assign arr_idx_o   = ptr_q[CELL_W-1:0];
  assign arr_wdata_o = prog_q ? (arr_old_i & pdata_q) : 16'hFFFF;
endmodule

// File: rtl/fcs_cell_array.sv
module fcs_cell_array #(
  parameter int CELL_W = 10,
  localparam int CELLS = 1 << CELL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CELL_W-1:0] widx_i,
  input  logic [15:0]       wdata_i,
  input  logic [CELL_W-1:0] ridx_a_i,
  output logic [15:0]       rdata_a_o,
  input  logic [CELL_W-1:0] ridx_b_i,
  output logic [15:0]       rdata_b_o
);
  logic [15:0] mem [CELLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= 16'hFFFF;
    end else if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[ridx_a_i];
  assign rdata_b_o = mem[ridx_b_i];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 20,
  parameter int GRAIN_W   = 10,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  localparam int CELL_W   = ADDR_W - GRAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       rd_data_o,
  output logic              busy_o,
  output logic              ry_by_o
);
  logic              wr_v, seq_start, seq_prog, seq_idle;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data, arr_wdata, arr_old;
  logic [CELL_W-1:0] lo_cell, hi_cell, arr_idx;
  logic              arr_we, arr_prog;

  fcs_bus_capture #(.ADDR_W(ADDR_W)) cap_i (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i, .data_i,
    .wr_v_o(wr_v), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fcs_cmd_fsm #(.ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W)) fsm_i (
    .clk_i, .rst_ni, .wr_v_i(wr_v), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy_o), .wp_ni, .start_o(seq_start), .prog_o(seq_prog),
    .lo_cell_o(lo_cell), .hi_cell_o(hi_cell), .idle_o(seq_idle)
  );

  fcs_op_engine #(.CELL_W(CELL_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) eng_i (
    .clk_i, .rst_ni, .start_i(seq_start), .prog_i(seq_prog),
    .lo_cell_i(lo_cell), .hi_cell_i(hi_cell), .pdata_i(wr_data),
    .arr_old_i(arr_old), .busy_o, .arr_we_o(arr_we), .arr_prog_o(arr_prog),
    .arr_idx_o(arr_idx), .arr_wdata_o(arr_wdata)
  );

  fcs_cell_array #(.CELL_W(CELL_W)) arr_i (
    .clk_i, .rst_ni, .we_i(arr_we), .widx_i(arr_idx), .wdata_i(arr_wdata),
    .ridx_a_i(addr_i[ADDR_W-1:GRAIN_W]), .rdata_a_o(rd_data_o),
    .ridx_b_i(arr_idx), .rdata_b_o(arr_old)
  );

  assign ry_by_o = ~busy_o;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W    = 20,
  parameter int GRAIN_W   = 10,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  localparam int WALK_MAX = (32768 >> GRAIN_W) + 1,
  localparam int M1       = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int LIMIT    = (M1 > WALK_MAX) ? M1 : WALK_MAX,
  localparam int RUN_W    = $clog2(LIMIT + 2)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        we_ni,
  input logic        busy_o,
  input logic        wr_v_i,
  input logic        seq_idle_i,
  input logic        arr_we_i,
  input logic        arr_prog_i,
  input logic [15:0] arr_wdata_i,
  input logic [15:0] arr_old_i
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!busy_o)                   run_q <= '0;
    else if (run_q != RUN_W'(LIMIT+1))  run_q <= run_q + 1'b1;
  end

  assert_write_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_i |-> busy_o);

  assert_busy_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RUN_W'(LIMIT)));

  assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_v_i) |=> seq_idle_i);

  assert_launch_on_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(!ce_ni && !we_ni, 2) && $past(ce_ni || we_ni)));

  assert_prog_clears_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_i && arr_prog_i) |-> ((arr_wdata_i & ~arr_old_i) == 16'h0000));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .busy_o(busy_o),
  .wr_v_i(wr_v), .seq_idle_i(seq_idle), .arr_we_i(arr_we), .arr_prog_i(arr_prog),
  .arr_wdata_i(arr_wdata), .arr_old_i(arr_old)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  localparam int AW = 20, GW = 10, PC = 8, EC = 16;
  localparam int NC = 1 << (AW - GW);
  localparam int unsigned SPACE = 1 << AW;
  localparam int unsigned TOPB  = SPACE - 8192;

  logic clk = 1'b0, rst_ni = 1'b0, ce_ni = 1'b1, we_ni = 1'b1, wp_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   data_i = '0;
  wire  [15:0]   rd_data_o;
  wire           busy_o, ry_by_o;

  flash_cmd_seq #(.ADDR_W(AW), .GRAIN_W(GW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk_i(clk), .rst_ni, .ce_ni, .we_ni, .wp_ni, .addr_i, .data_i,
    .rd_data_o, .busy_o, .ry_by_o
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [NC];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a0, input int unsigned a1,
                    input logic [15:0] d0, input logic [15:0] d1, input bit ce_on);
    @(negedge clk); addr_i = AW'(a0); data_i = d0; ce_ni = !ce_on; we_ni = 1'b1;
    @(negedge clk); we_ni = 1'b0;
    @(negedge clk); addr_i = AW'(a1); data_i = d1;
    @(negedge clk); we_ni = 1'b1; ce_ni = 1'b1;
  endtask

  task automatic wr1(input int unsigned a, input logic [15:0] d);
    wr(a, a, d, d, 1'b1);
  endtask

  task automatic prefix();
    wr1(32'h555, 16'h00AA);
    wr1(32'h2AA, 16'h0055);
  endtask

  task automatic prog_seq(input int unsigned a, input logic [15:0] d);
    prefix(); wr1(32'h555, 16'h00A0); wr1(a, d);
  endtask

  task automatic erase_seq(input int unsigned a, input logic [15:0] op);
    prefix(); wr1(32'h555, 16'h0080); prefix(); wr1(a, op);
  endtask

  task automatic busy_len(output int n);
    @(negedge clk);
    n = 0;
    if (busy_o) check("R9", 32'(ry_by_o), 32'd0);
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
    check("R9", 32'(ry_by_o), 32'd1);
  endtask

  function automatic bit blocked(input int unsigned lo, input int unsigned hi);
    return !wp_ni && (lo < 8192 || hi >= TOPB);
  endfunction

  task automatic do_prog(input string req, input int unsigned a, input logic [15:0] d);
    int n;
    bit acc;
    prog_seq(a, d);
    busy_len(n);
    acc = !blocked(a, a);
    if (acc) model[a >> GW] &= d;
    check(req, n, acc ? PC : 0);
  endtask

  task automatic do_erase(input string req, input int unsigned a, input bit blk);
    int n, cells, exp;
    int unsigned lo, sz;
    bit acc;
    if (!blk) begin lo = a & ~32'd2047; sz = 2048; end
    else if (a < 8192)  begin lo = 0;     sz = 8192;  end
    else if (a < 12288) begin lo = 8192;  sz = 4096;  end
    else if (a < 16384) begin lo = 12288; sz = 4096;  end
    else if (a < 32768) begin lo = 16384; sz = 16384; end
    else begin lo = a & ~32'd32767; sz = 32768; end
    erase_seq(a, blk ? 16'h0030 : 16'h0050);
    busy_len(n);
    acc = !blocked(lo, lo + sz - 1);
    cells = int'(sz >> GW);
    if (acc) for (int c = 0; c < cells; c++) model[(lo >> GW) + c] = 16'hFFFF;
    exp = acc ? ((EC > cells + 1) ? EC : cells + 1) : 0;
    check(req, n, exp);
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < NC; i++) begin
      addr_i = AW'(i << GW);
      #1;
      check(req, 32'(rd_data_o), 32'(model[i]));
    end
  endtask

  task automatic run_tests();
    int n;
    for (int i = 0; i < NC; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", 32'(busy_o), 32'd0);
    check("R10", 32'(ry_by_o), 32'd1);
    cmp_all("R10");

    // R3/R9: program every cell, then AND a second pattern into every eighth
    for (int i = 0; i < NC; i++)
      do_prog("R9", (i << GW) | ((i * 7) & 1023), 16'((i * 40503) ^ 16'h5A5A));
    cmp_all("R3");
    for (int i = 0; i < NC; i += 8)
      do_prog("R9", i << GW, 16'h0F0F ^ 16'(i));
    cmp_all("R3");

    // R4: sector erase sweep
    for (int s = 0; s < NC / 2; s += 3)
      do_erase("R4", (s << 11) + ((s * 13) & 2047), 1'b0);
    cmp_all("R4");

    // R5: every block of the map
    begin
      int unsigned a = 0;
      while (a < SPACE) begin
        int unsigned sz;
        sz = (a < 8192) ? 8192 : (a < 16384) ? 4096 : (a < 32768) ? 16384 : 32768;
        do_prog("R9", a, 16'h0000);
        do_erase("R5", a + sz / 2, 1'b1);
        a += sz;
      end
    end
    cmp_all("R5");

    // R8: boot protection
    wp_ni = 1'b1;
    do_erase("R4", 32'h00000, 1'b0);
    do_erase("R4", 32'hFF800, 1'b0);
    do_prog("R3", 32'h01800, 16'h0000);
    do_prog("R3", 32'hFA000, 16'h0000);
    wp_ni = 1'b0;
    do_prog("R8", 32'h00010, 16'h0000);
    do_prog("R8", 32'hFFC05, 16'h0000);
    do_prog("R8", 32'h02000, 16'h0000);
    do_erase("R8", 32'h01800, 1'b0);
    do_erase("R8", 32'hF8000, 1'b1);
    do_erase("R8", 32'h08000, 1'b1);
    cmp_all("R8");
    wp_ni = 1'b1;

    // R7: full command while busy is ignored
    do_prog("R3", 100 << GW, 16'h00FF);
    erase_seq(32'h08005, 16'h0030);
    for (int c = 32; c < 64; c++) model[c] = 16'hFFFF;
    prog_seq(100 << GW, 16'h0000);
    wr1(100 << GW, 16'h0000);
    @(negedge clk);
    check("R7", 32'(busy_o), 32'd1);
    while (busy_o) @(negedge clk);
    wr1(100 << GW, 16'h0000);
    busy_len(n);
    check("R7", n, 0);
    cmp_all("R7");

    // R6/R2: broken prefixes and bad opcode
    do_erase("R4", 200 << GW, 1'b0);
    wr1(32'h555, 16'h00AA); wr1(32'h2AB, 16'h0055);
    wr1(32'h555, 16'h00A0); wr1(200 << GW, 16'h0000);
    busy_len(n); check("R6", n, 0);
    wr1(32'h555, 16'h00AA); wr1(32'h2AA, 16'h0056);
    wr1(32'h555, 16'h00A0); wr1(200 << GW, 16'h0000);
    busy_len(n); check("R6", n, 0);
    prefix(); wr1(32'h554, 16'h00A0); wr1(200 << GW, 16'h0000);
    busy_len(n); check("R2", n, 0);
    erase_seq(201 << GW, 16'h0010);
    busy_len(n); check("R2", n, 0);
    cmp_all("R6");
    do_prog("R6", (200 << GW) + 3, 16'h1234);
    cmp_all("R6");

    // R1: no write without chip enable; address and data capture edges
    do_erase("R4", 300 << GW, 1'b0);
    wr(32'h555, 32'h555, 16'h00AA, 16'h00AA, 1'b0);
    wr(32'h2AA, 32'h2AA, 16'h0055, 16'h0055, 1'b0);
    wr(32'h555, 32'h555, 16'h00A0, 16'h00A0, 1'b0);
    wr(300 << GW, 300 << GW, 16'h0000, 16'h0000, 1'b0);
    busy_len(n); check("R1", n, 0);
    prefix(); wr1(32'h555, 16'h00A0);
    wr(300 << GW, 301 << GW, 16'h0000, 16'hF0F0, 1'b1);
    busy_len(n); check("R1", n, PC);
    model[300] &= 16'hF0F0;
    cmp_all("R1");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule